// File: doc/BRIEF.md
# Sound-RAM Halfword DMA Engine

This block carries 16-bit halfwords between a streaming host port and a sound RAM of 2^20 halfwords. It runs one transfer at a time for one of several channels. Each channel has its own transfer address register. A read streams words from RAM to the host. A write streams words from the host into RAM. The engine moves at most one halfword per clock and waits whenever the host side is not ready or not valid.

Each channel also has an interrupt address and an enable. On a read, every word address is compared with that channel's interrupt address. On a write, the address reached at the end of the transfer is compared with a small window below the interrupt address. A hit sets that channel's sticky interrupt-info bit. When a transfer finishes, the engine applies the end-of-transfer address adjustment for its direction. It then raises the channel's completion flag. Software acknowledges completion per channel. The acknowledge restores the channel's ready status bit and clears its mode bit.

The RAM port has an asynchronous read: `ram_rdata_i` must reflect `ram_addr_o` in the same cycle. The transfer address of a channel is loaded through `addr_wr_i` while the engine is idle.

Top module: `snd_dma_engine`

## Requirements
- R1: After reset, every channel has its ready status bit at 1 and its mode, completion and interrupt-info bits at 0. Every transfer address is 0, `busy_o` is 0, and `ram_en_o` is 0.
- R2: A start or an address load is taken only while `busy_o` is 0. `busy_o` rises in the cycle after a start of non-zero length. A start or address load presented while busy changes no transfer address and no flag.
- R3: A start clears the channel's ready status bit, sets its mode bit and clears its completion flag. An acknowledge (`ack_i` with `ack_ch_i`) sets the ready status bit and clears the mode bit and the completion flag; when a start and an acknowledge name the same channel in the same cycle, the start wins.
- R4: A read (`start_rd_i`=1) presents RAM address = transfer address with `host_out_valid_o`=1 and `host_out_data_o`=`ram_rdata_i`. Each accepted word (valid and `host_out_ready_i`) increments the address, and 0xFFFFF wraps to 0.
- R5: During a read, when the interrupt of the channel is enabled and an accepted word's address equals its interrupt address, bit [channel] of `irq_info_o` is set.
- R6: After the last accepted read word, the transfer address equals the incremented address plus 19, modulo 2^20, and the engine returns to idle.
- R7: A write (`start_rd_i`=0) asserts `host_in_ready_o`. Each cycle with `host_in_valid_i` writes `host_in_data_i` at the current address and increments it, so the final address is the start address plus the length.
- R8: At the end of a write with the interrupt enabled, bit [channel] of `irq_info_o` is set when the interrupt address is strictly greater than the final address and at most final address + 0x20.
- R9: If the final write address exceeds 0xFFFFE, the transfer address becomes 0x2800. The window test of R8 uses the address before this restart.
- R10: A start with length 0 sets the completion flag in the next cycle without entering busy, issues no RAM access and leaves the transfer address unchanged.
- R11: `irq_clr_i` bit [channel] clears that interrupt-info bit. A hit in the same cycle wins.
- R12: Every completed transfer of non-zero length, in either direction, sets `done_o` bit [channel] in the cycle after its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a transfer (taken when idle) |
| start_ch_i | input | CH_W | Channel of the transfer |
| start_rd_i | input | 1 | 1 = RAM to host, 0 = host to RAM |
| start_len_i | input | LEN_W | Number of halfwords |
| addr_wr_i | input | 1 | Load a transfer address (taken when idle) |
| addr_wr_ch_i | input | CH_W | Channel to load |
| addr_wr_data_i | input | ADDR_W | Address value |
| ack_i | input | 1 | Acknowledge completion |
| ack_ch_i | input | CH_W | Channel acknowledged |
| irq_en_i | input | NUM_CH | Per-channel interrupt enable |
| irq_addr_i | input | NUM_CH x ADDR_W | Per-channel interrupt address |
| irq_clr_i | input | NUM_CH | Clear interrupt-info bits |
| host_in_valid_i | input | 1 | Write data valid |
| host_in_data_i | input | 16 | Write data |
| host_in_ready_o | output | 1 | Engine takes write data |
| host_out_valid_o | output | 1 | Read data valid |
| host_out_data_o | output | 16 | Read data |
| host_out_ready_i | input | 1 | Host takes read data |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM halfword address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data (same cycle) |
| busy_o | output | 1 | Transfer in progress |
| rdy_stat_o | output | NUM_CH | Per-channel ready status bit |
| mode_o | output | NUM_CH | Per-channel transfer mode bit |
| done_o | output | NUM_CH | Per-channel completion flag |
| irq_info_o | output | NUM_CH | Per-channel sticky interrupt info |
| xfer_addr_o | output | NUM_CH x ADDR_W | Per-channel transfer address |

## Verification
The assertions take the channel fields to be smaller than NUM_CH, and they take `ram_rdata_i` to follow `ram_addr_o` combinationally. They do not cover an acknowledge of the channel that is being transferred. The stimulus uses only the two channels of the default build and acknowledges a channel only after its transfer has finished. It feeds read data from a fixed function of the RAM address. Starts and address loads during a transfer are issued on purpose, to show that they are dropped.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RD   = 2'd1,
        XS_WR   = 2'd2
    } xfer_state_e;

    localparam int unsigned DEF_ADDR_W  = 20;
    localparam int unsigned DEF_LEN_W   = 16;
    localparam int unsigned DEF_RD_BUMP = 19;
    localparam int unsigned DEF_RESTART = 32'h2800;
    localparam int unsigned DEF_IRQ_WIN = 32'h20;

endpackage

// File: rtl/snd_dma_addr_step.sv
module snd_dma_addr_step #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned RD_BUMP = 19,
    parameter int unsigned RESTART = 32'h2800
) (
    input  logic [ADDR_W-1:0] cur_i,
    output logic [ADDR_W-1:0] inc_o,
    output logic [ADDR_W-1:0] rd_final_o,
    output logic [ADDR_W-1:0] wr_final_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    // natural wrap of the top address to zero
    assign inc_o      = cur_i + ADDR_W'(1);
    assign rd_final_o = inc_o + ADDR_W'(RD_BUMP);
    assign wr_final_o = (inc_o > TOP - ADDR_W'(1)) ? ADDR_W'(RESTART) : inc_o;
endmodule

// File: rtl/snd_dma_irq_match.sv
module snd_dma_irq_match #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned IRQ_WIN = 32'h20
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] irq_addr_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] fin_i,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    logic [ADDR_W:0] lo, hi, tgt;

    assign lo  = {1'b0, fin_i};
    assign hi  = lo + (ADDR_W+1)'(IRQ_WIN);
    assign tgt = {1'b0, irq_addr_i};

    assign rd_hit_o = en_i && (irq_addr_i == cur_i);
    assign wr_hit_o = en_i && (tgt > lo) && (tgt <= hi);
endmodule

// File: rtl/snd_dma_engine.sv
module snd_dma_engine
    import snd_dma_pkg::*;
#(
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned LEN_W   = DEF_LEN_W,
    parameter int unsigned RD_BUMP = DEF_RD_BUMP,
    parameter int unsigned RESTART = DEF_RESTART,
    parameter int unsigned IRQ_WIN = DEF_IRQ_WIN,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [CH_W-1:0]                start_ch_i,
    input  logic                           start_rd_i,
    input  logic [LEN_W-1:0]               start_len_i,
    input  logic                           addr_wr_i,
    input  logic [CH_W-1:0]                addr_wr_ch_i,
    input  logic [ADDR_W-1:0]              addr_wr_data_i,
    input  logic                           ack_i,
    input  logic [CH_W-1:0]                ack_ch_i,
    input  logic [NUM_CH-1:0]              irq_en_i,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  irq_addr_i,
    input  logic [NUM_CH-1:0]              irq_clr_i,
    input  logic                           host_in_valid_i,
    input  logic [15:0]                    host_in_data_i,
    output logic                           host_in_ready_o,
    output logic                           host_out_valid_o,
    output logic [15:0]                    host_out_data_o,
    input  logic                           host_out_ready_i,
    output logic                           ram_en_o,
    output logic                           ram_we_o,
    output logic [ADDR_W-1:0]              ram_addr_o,
    output logic [15:0]                    ram_wdata_o,
    input  logic [15:0]                    ram_rdata_i,
    output logic                           busy_o,
    output logic [NUM_CH-1:0]              rdy_stat_o,
    output logic [NUM_CH-1:0]              mode_o,
    output logic [NUM_CH-1:0]              done_o,
    output logic [NUM_CH-1:0]              irq_info_o,
    output logic [NUM_CH-1:0][ADDR_W-1:0]  xfer_addr_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    typedef struct packed {
        xfer_state_e                   st;
        logic [CH_W-1:0]               ch;
        logic [LEN_W-1:0]              left;
        logic [NUM_CH-1:0][ADDR_W-1:0] addr;
        logic [NUM_CH-1:0]             stat;
        logic [NUM_CH-1:0]             mode;
        logic [NUM_CH-1:0]             done;
        logic [NUM_CH-1:0]             irqi;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] act_addr, inc, rd_final, wr_final;
    logic              rd_hit, wr_hit, rd_hs, wr_hs, last;

    assign act_addr = q.addr[q.ch];
    assign rd_hs    = (q.st == XS_RD) && host_out_ready_i;
    assign wr_hs    = (q.st == XS_WR) && host_in_valid_i;
    assign last     = (q.left == LEN_W'(1));

    snd_dma_addr_step #(
        .ADDR_W  (ADDR_W),
        .RD_BUMP (RD_BUMP),
        .RESTART (RESTART)
    ) i_step (
        .cur_i      (act_addr),
        .inc_o      (inc),
        .rd_final_o (rd_final),
        .wr_final_o (wr_final)
    );

    snd_dma_irq_match #(
        .ADDR_W  (ADDR_W),
        .IRQ_WIN (IRQ_WIN)
    ) i_match (
        .en_i       (irq_en_i[q.ch]),
        .irq_addr_i (irq_addr_i[q.ch]),
        .cur_i      (act_addr),
        .fin_i      (inc),
        .rd_hit_o   (rd_hit),
        .wr_hit_o   (wr_hit)
    );

    always_comb begin
        d      = q;
        d.irqi = q.irqi & ~irq_clr_i;
        if (ack_i) begin
            d.stat[ack_ch_i] = 1'b1;
            d.mode[ack_ch_i] = 1'b0;
            d.done[ack_ch_i] = 1'b0;
        end
        unique case (q.st)
            XS_IDLE: begin
                if (addr_wr_i) begin
                    d.addr[addr_wr_ch_i] = addr_wr_data_i;
                end
                if (start_i) begin
                    d.ch               = start_ch_i;
                    d.left             = start_len_i;
                    d.stat[start_ch_i] = 1'b0;
                    d.mode[start_ch_i] = 1'b1;
                    d.done[start_ch_i] = 1'b0;
                    if (start_len_i == '0) begin
                        d.done[start_ch_i] = 1'b1;
                    end else begin
                        d.st = start_rd_i ? XS_RD : XS_WR;
                    end
                end
            end
            XS_RD: begin
                if (host_out_ready_i) begin
                    if (rd_hit) d.irqi[q.ch] = 1'b1;
                    d.left = q.left - LEN_W'(1);
                    if (last) begin
                        d.addr[q.ch] = rd_final;
                        d.done[q.ch] = 1'b1;
                        d.st         = XS_IDLE;
                    end else begin
                        d.addr[q.ch] = inc;
                    end
                end
            end
            XS_WR: begin
                if (host_in_valid_i) begin
                    d.left = q.left - LEN_W'(1);
                    if (last) begin
                        if (wr_hit) d.irqi[q.ch] = 1'b1;
                        d.addr[q.ch] = wr_final;
                        d.done[q.ch] = 1'b1;
                        d.st         = XS_IDLE;
                    end else begin
                        d.addr[q.ch] = inc;
                    end
                end
            end
            default: d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: XS_IDLE, ch: '0, left: '0, addr: '0,
                   stat: '1, mode: '0, done: '0, irqi: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o           = (q.st != XS_IDLE);
    assign host_out_valid_o = (q.st == XS_RD);
    assign host_in_ready_o  = (q.st == XS_WR);
    assign host_out_data_o  = ram_rdata_i;
    assign ram_en_o         = (q.st == XS_RD) || wr_hs;
    assign ram_we_o         = wr_hs;
    assign ram_addr_o       = act_addr;
    assign ram_wdata_o      = host_in_data_i;
    assign rdy_stat_o       = q.stat;
    assign mode_o           = q.mode;
    assign done_o           = q.done;
    assign irq_info_o       = q.irqi;
    assign xfer_addr_o      = q.addr;

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_in_ready_o && host_out_valid_o)); // R2
    AST_IDLE_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ram_en_o); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rdy_stat_o[q.ch]); // R3
    AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hs && !last && ram_addr_o == TOP) |=> (ram_addr_o == '0)); // R4
    AST_WR_NO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hs && last) |=> (xfer_addr_o[q.ch] != TOP)); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hs || wr_hs) && last) |=> (done_o[q.ch] && !busy_o)); // R12
endmodule

// File: tb/test_snd_dma_engine.sv
module test_snd_dma_engine;
    localparam int AW = 20;
    localparam int LW = 16;
    localparam int NC = 2;
    localparam int MAXA = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, start_rd_i = 0, addr_wr_i = 0, ack_i = 0;
    logic [0:0] start_ch_i = 0, addr_wr_ch_i = 0, ack_ch_i = 0;
    logic [LW-1:0] start_len_i = 0;
    logic [AW-1:0] addr_wr_data_i = 0;
    logic [NC-1:0] irq_en_i = 0, irq_clr_i = 0;
    logic [NC-1:0][AW-1:0] irq_addr_i = '0;
    logic host_in_valid_i = 0, host_out_ready_i = 0;
    logic [15:0] host_in_data_i = 0;
    logic host_in_ready_o, host_out_valid_o, ram_en_o, ram_we_o, busy_o;
    logic [15:0] host_out_data_o, ram_wdata_o, ram_rdata_i;
    logic [AW-1:0] ram_addr_o;
    logic [NC-1:0] rdy_stat_o, mode_o, done_o, irq_info_o;
    logic [NC-1:0][AW-1:0] xfer_addr_o;

    always #4 clk = ~clk;
    assign ram_rdata_i = ram_addr_o[15:0] ^ 16'hA5C3;

    snd_dma_engine i_snd_dma_engine (.*);

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_busy, m_rd;
    int m_ch, m_left;
    int m_addr[NC];
    bit m_stat[NC], m_mode[NC], m_done[NC], m_irq[NC];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rd = 0; m_ch = 0; m_left = 0;
            for (int c = 0; c < NC; c++) begin
                m_addr[c] = 0; m_stat[c] = 1; m_mode[c] = 0; m_done[c] = 0; m_irq[c] = 0;
            end
        end else begin
            for (int c = 0; c < NC; c++) if (irq_clr_i[c]) m_irq[c] = 0;
            if (ack_i) begin
                m_stat[ack_ch_i] = 1; m_mode[ack_ch_i] = 0; m_done[ack_ch_i] = 0;
            end
            if (!m_busy) begin
                if (addr_wr_i) m_addr[addr_wr_ch_i] = int'(addr_wr_data_i);
                if (start_i) begin
                    m_ch = int'(start_ch_i);
                    m_stat[m_ch] = 0; m_mode[m_ch] = 1; m_done[m_ch] = 0;
                    if (start_len_i == 0) m_done[m_ch] = 1;
                    else begin m_busy = 1; m_rd = start_rd_i; m_left = int'(start_len_i); end
                end
            end else if (m_rd && host_out_ready_i) begin
                if (irq_en_i[m_ch] && int'(irq_addr_i[m_ch]) == m_addr[m_ch]) m_irq[m_ch] = 1;
                m_addr[m_ch] = (m_addr[m_ch] == MAXA) ? 0 : m_addr[m_ch] + 1;
                m_left--;
                if (m_left == 0) begin
                    m_addr[m_ch] = (m_addr[m_ch] + 19) & MAXA;
                    m_done[m_ch] = 1; m_busy = 0;
                end
            end else if (!m_rd && host_in_valid_i) begin
                m_addr[m_ch] = (m_addr[m_ch] + 1) & MAXA;
                m_left--;
                if (m_left == 0) begin
                    if (irq_en_i[m_ch] && int'(irq_addr_i[m_ch]) > m_addr[m_ch]
                        && int'(irq_addr_i[m_ch]) <= m_addr[m_ch] + 32) m_irq[m_ch] = 1;
                    if (m_addr[m_ch] > MAXA - 1) m_addr[m_ch] = 32'h2800;
                    m_done[m_ch] = 1; m_busy = 0;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk); #2;
            chk("R2 busy", busy_o, m_busy);
            chk("R4 out_valid", host_out_valid_o, m_busy && m_rd);
            chk("R7 in_ready", host_in_ready_o, m_busy && !m_rd);
            chk("R10 ram_en", ram_en_o, m_busy && (m_rd || host_in_valid_i));
            chk("R7 ram_we", ram_we_o, m_busy && !m_rd && host_in_valid_i);
            if (m_busy && m_rd) begin
                chk("R4 ram_addr", ram_addr_o, m_addr[m_ch]);
                chk("R4 out_data", host_out_data_o, m_addr[m_ch][15:0] ^ 16'hA5C3);
            end
            if (ram_we_o) begin
                chk("R7 wr_addr", ram_addr_o, m_addr[m_ch]);
                chk("R7 wr_data", ram_wdata_o, host_in_data_i);
            end
            for (int c = 0; c < NC; c++) begin
                chk("R3 stat", rdy_stat_o[c], m_stat[c]);
                chk("R3 mode", mode_o[c], m_mode[c]);
                chk("R12 done", done_o[c], m_done[c]);
                chk("R5 R8 R11 irq", irq_info_o[c], m_irq[c]);
                chk("R6 R9 xfer_addr", xfer_addr_o[c], m_addr[c]);
            end
        end
    end

    task automatic load(int ch, int val);
        @(negedge clk); addr_wr_i = 1; addr_wr_ch_i = 1'(ch); addr_wr_data_i = AW'(val);
        @(negedge clk); addr_wr_i = 0;
    endtask

    task automatic go(int ch, bit rd, int len);
        @(negedge clk); start_i = 1; start_ch_i = 1'(ch); start_rd_i = rd; start_len_i = LW'(len);
        @(negedge clk); start_i = 0;
    endtask

    task automatic run_rd(logic [7:0] pat);
        int k = 0;
        while (m_busy) begin host_out_ready_i = pat[k % 8]; k++; @(negedge clk); end
        host_out_ready_i = 0;
    endtask

    task automatic run_wr(logic [7:0] pat, bit poke);
        int k = 0;
        while (m_busy) begin
            host_in_valid_i = pat[k % 8]; host_in_data_i = 16'(k * 37 + 5);
            start_i = poke && (k == 1); start_ch_i = 0; start_rd_i = 1; start_len_i = 7;
            addr_wr_i = poke && (k == 1); addr_wr_ch_i = 1; addr_wr_data_i = 20'h12345;
            k++; @(negedge clk);
        end
        host_in_valid_i = 0; start_i = 0; addr_wr_i = 0;
    endtask

    task automatic ack(int ch);
        @(negedge clk); ack_i = 1; ack_ch_i = 1'(ch);
        @(negedge clk); ack_i = 0;
    endtask

    task automatic clr(int ch);
        @(negedge clk); irq_clr_i = NC'(1 << ch);
        @(negedge clk); irq_clr_i = 0;
    endtask

    task automatic settle;
        @(negedge clk); #3;
    endtask

    task automatic win_case(int ia, bit exp);
        irq_en_i[0] = 1; irq_addr_i[0] = AW'(ia);
        load(0, 32'h300); go(0, 0, 1); run_wr(8'hFF, 0); settle();
        chk("R8 window edge", irq_info_o[0], exp);
        clr(0); ack(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R1 reset stat", rdy_stat_o, 2'b11);
        chk("R1 reset flags", {mode_o, done_o, irq_info_o}, 0);
        chk("R1 reset addr", {xfer_addr_o, busy_o, ram_en_o}, 0);

        // read with a word hit, continuous ready
        irq_en_i[0] = 1; irq_addr_i[0] = 20'h00102;
        load(0, 32'h100); go(0, 1, 4); run_rd(8'hFF); settle();
        chk("R6 read end addr", xfer_addr_o[0], 32'h117);
        chk("R5 read hit", irq_info_o[0], 1);
        chk("R12 read done", done_o[0], 1);
        chk("R3 stat low before ack", rdy_stat_o[0], 0);
        ack(0); settle();
        chk("R3 ack", {rdy_stat_o[0], mode_o[0], done_o[0]}, 3'b100);
        clr(0); settle();
        chk("R11 irq clear", irq_info_o[0], 0);

        // read across the top of memory, hit at address 0, gaps in ready
        irq_en_i[1] = 1; irq_addr_i[1] = 0;
        load(1, 32'hFFFFE); go(1, 1, 3); run_rd(8'b1011_0110); settle();
        chk("R4 R6 wrap end addr", xfer_addr_o[1], 32'h14);
        chk("R5 hit after wrap", irq_info_o[1], 1);
        ack(1); clr(1);

        // write with window hit and valid gaps
        irq_addr_i[0] = 20'h215;
        load(0, 32'h200); go(0, 0, 5); run_wr(8'b1101_1010, 0); settle();
        chk("R7 write end addr", xfer_addr_o[0], 32'h205);
        chk("R8 window hit", irq_info_o[0], 1);
        ack(0); clr(0);

        // write reaching the top: restart
        irq_en_i[1] = 0; irq_addr_i[1] = 20'hFFFFF;
        load(1, 32'hFFFF0); go(1, 0, 15); run_wr(8'hFF, 0); settle();
        chk("R9 restart", xfer_addr_o[1], 32'h2800);
        chk("R9 no irq when disabled", irq_info_o[1], 0);
        ack(1);

        // window boundaries around final address 0x301
        win_case(32'h321, 1);
        win_case(32'h322, 0);
        win_case(32'h301, 0);

        // zero length
        go(1, 1, 0);
        chk("R10 zero length done", done_o[1], 1);
        chk("R10 zero length addr", xfer_addr_o[1], 32'h2800);
        ack(1);

        // start and load while busy are dropped
        go(1, 0, 3); run_wr(8'hFF, 1); settle();
        chk("R2 load ignored", xfer_addr_o[1], 32'h2803);
        chk("R2 start ignored", {busy_o, mode_o[0]}, 0);
        ack(1); settle();

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule